// File: doc/BRIEF.md
# Nonvolatile Write Guard with Status Register

This block holds the configuration and status byte of a serial nonvolatile memory with a supervisor function. It also decides whether each nonvolatile write asked for by the serial command controller may start. The controller sends single-cycle strobes: set latch, clear latch, status write with its data byte, opening of an array write, each array data byte with its 9-bit address, array commit, and end of the internal write cycle. The block answers with a per-byte permit, and with a start pulse for each accepted status or array write.

A write starts only if all of these hold: the volatile enable latch is set, the write-protect pin is high, no internal cycle is running, and no byte of the page lies in the protected range. A two-bit range code chooses the protected range: none, the top quarter, the top half or the whole array. Protected locations can still be read; only writes to them are refused. Taking the pin low clears the latch. A write that has been loaded but not yet committed is therefore cancelled. A cycle that has already started runs to its end.

Top module: `nvw_guard`

## Requirements
- R1: After reset, status_o reads 30h and wd_sel_o reads 2'b11. Bits 7:6 of status_o always read 0.
- R2: The enable flag (status_o bit 1) is set by wren_i while wp_level_i is high. It is cleared by wrdi_i and by por_i.
- R3: An accepted status write copies sr_data_i bits 5:2 into the watchdog select (status bits 5:4, also on wd_sel_o) and the range code (status bits 3:2). The other data bits are ignored. One cycle later, sr_go_o pulses and the busy flag (status bit 0) is set.
- R4: done_i while busy clears both the busy flag and the enable flag.
- R5: A status or array commit made while the enable flag is 0 is rejected. No go pulse follows, and status_o is unchanged.
- R6: Range codes select the protected addresses: 00 protects none, 01 protects 180h-1FFh, 10 protects 100h-1FFh, 11 protects all. byte_ok_o is high only for an unprotected address while the flag is set, the pin is high and the block is not busy.
- R7: An array commit is rejected as a whole if any byte since the last arr_open_i hit the protected range. The enable flag is left set.
- R8: A rejected write never raises the busy flag. The busy flag rises only together with a go pulse.
- R9: wp_level_i low clears the enable flag and keeps wren_i from setting it. A write loaded before the pin went low is then rejected at commit.
- R10: wp_level_i going low while busy leaves the busy flag set until done_i.
- R11: Commits made while busy are rejected, and the stored configuration does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on flag, clears the enable flag |
| wp_level_i | input | 1 | Write-protect pin level, low blocks writes |
| wren_i | input | 1 | Set-latch command strobe |
| wrdi_i | input | 1 | Clear-latch command strobe |
| sr_commit_i | input | 1 | Status write commit strobe |
| sr_data_i | input | 8 | Data byte of the status write |
| arr_open_i | input | 1 | Array write opcode accepted |
| byte_vld_i | input | 1 | An array data byte was received |
| byte_addr_i | input | 9 | Address of that byte |
| arr_commit_i | input | 1 | Array write commit strobe |
| done_i | input | 1 | Internal write cycle finished |
| status_o | output | 8 | Status byte for readback |
| wd_sel_o | output | 2 | Watchdog period select |
| byte_ok_o | output | 1 | Permit for the byte at byte_addr_i |
| arr_go_o | output | 1 | Start pulse of an array write |
| sr_go_o | output | 1 | Start pulse of a status write |

## Verification
Some rules are checked by the assertions on every cycle. The busy flag only rises with a go pulse. No go pulse comes without the enable flag set. A low pin leaves the flag clear on the next cycle. A status write loads exactly the four data bits. The whole-array code never grants a byte. The bench scenarios cover the rest. These are the exact boundaries of each range code, rejection of a whole page for a single protected byte while the flag stays set, and cancellation by the pin between load and commit. They also cover the busy flag surviving a pin drop, and commits refused during a running cycle.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    typedef enum logic [1:0] {
        GUARD_NONE    = 2'b00,
        GUARD_QUARTER = 2'b01,
        GUARD_HALF    = 2'b10,
        GUARD_ALL     = 2'b11
    } guard_code_e;

    typedef struct packed {
        logic [1:0]  wd_sel;
        guard_code_e guard;
    } nv_cfg_t;

    localparam logic [1:0] WD_DEFAULT = 2'b11;

    function automatic logic [7:0] pack_status(nv_cfg_t cfg, logic wel, logic wip);
        return {2'b00, cfg.wd_sel, cfg.guard, wel, wip};
    endfunction

endpackage

// File: rtl/nvw_range_dec.sv
module nvw_range_dec
    import nvw_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  guard_code_e       code_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (code_i)
            GUARD_NONE:    hit_o = 1'b0;
            GUARD_QUARTER: hit_o = addr_i[TOP] & addr_i[TOP-1];
            GUARD_HALF:    hit_o = addr_i[TOP];
            default:       hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/nvw_enable_latch.sv
module nvw_enable_latch (
    input  logic clk,
    input  logic rst,
    input  logic por_i,
    input  logic wp_level_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic cycle_end_i,
    output logic wel_o
);
    logic force_clr;

    assign force_clr = por_i | ~wp_level_i | cycle_end_i;

    always_ff @(posedge clk) begin
        if (rst)            wel_o <= 1'b0;
        else if (force_clr) wel_o <= 1'b0;
        else if (clr_i)     wel_o <= 1'b0;
        else if (set_i)     wel_o <= 1'b1;
    end
endmodule

// File: rtl/nvw_cfg_store.sv
module nvw_cfg_store
    import nvw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  nv_cfg_t next_i,
    output nv_cfg_t cfg_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o.wd_sel <= WD_DEFAULT;
            cfg_o.guard  <= GUARD_NONE;
        end else if (load_i) begin
            cfg_o <= next_i;
        end
    end
endmodule

// File: rtl/nvw_guard.sv
module nvw_guard
    import nvw_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_i,
    input  logic              wp_level_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              sr_commit_i,
    input  logic [DATA_W-1:0] sr_data_i,
    input  logic              arr_open_i,
    input  logic              byte_vld_i,
    input  logic [ADDR_W-1:0] byte_addr_i,
    input  logic              arr_commit_i,
    input  logic              done_i,
    output logic [7:0]        status_o,
    output logic [1:0]        wd_sel_o,
    output logic              byte_ok_o,
    output logic              arr_go_o,
    output logic              sr_go_o
);
    localparam int CFG_LSB = 2;
    localparam int CFG_W   = $bits(nv_cfg_t);

    logic    wel, wip;
    logic    page_bad_q;
    logic    hit;
    logic    may_write;
    logic    arr_accept, sr_accept;
    logic    cycle_end;
    nv_cfg_t cfg, cfg_next;
    logic    unused_sr_bits;

    assign unused_sr_bits = ^{sr_data_i[DATA_W-1:CFG_LSB+CFG_W], sr_data_i[CFG_LSB-1:0]};

    nvw_range_dec #(.ADDR_W(ADDR_W)) u_dec (
        .code_i (cfg.guard),
        .addr_i (byte_addr_i),
        .hit_o  (hit)
    );

    assign cycle_end = done_i & wip;

    nvw_enable_latch u_latch (
        .clk         (clk),
        .rst         (rst),
        .por_i       (por_i),
        .wp_level_i  (wp_level_i),
        .set_i       (wren_i),
        .clr_i       (wrdi_i),
        .cycle_end_i (cycle_end),
        .wel_o       (wel)
    );

    assign may_write  = wel & wp_level_i & ~wip;
    assign byte_ok_o  = may_write & ~hit;
    assign arr_accept = arr_commit_i & may_write & ~page_bad_q & ~(byte_vld_i & hit);
    assign sr_accept  = sr_commit_i & may_write & ~arr_accept;

    assign cfg_next = nv_cfg_t'(sr_data_i[CFG_LSB+CFG_W-1:CFG_LSB]);

    nvw_cfg_store u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_i (sr_accept),
        .next_i (cfg_next),
        .cfg_o  (cfg)
    );

    always_ff @(posedge clk) begin
        if (rst)                      page_bad_q <= 1'b0;
        else if (arr_open_i)          page_bad_q <= 1'b0;
        else if (byte_vld_i && hit)   page_bad_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wip      <= 1'b0;
            arr_go_o <= 1'b0;
            sr_go_o  <= 1'b0;
        end else begin
            arr_go_o <= arr_accept;
            sr_go_o  <= sr_accept;
            if (arr_accept || sr_accept) wip <= 1'b1;
            else if (cycle_end)          wip <= 1'b0;
        end
    end

    assign status_o = pack_status(cfg, wel, wip);
    assign wd_sel_o = cfg.wd_sel;
endmodule

// File: rtl/nvw_guard_chk.sv
module nvw_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       wp_level_i,
    input logic       done_i,
    input logic [7:0] sr_data_i,
    input logic [7:0] status_o,
    input logic       byte_ok_o,
    input logic       arr_go_o,
    input logic       sr_go_o
);
    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[7:6] == 2'b00);

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[0]) |-> (arr_go_o || sr_go_o));

    // R5
    go_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_go_o || sr_go_o) |-> $past(status_o[1]));

    // R9
    wp_clears_wel_chk: assert property (@(posedge clk) disable iff (rst)
        !wp_level_i |=> !status_o[1]);

    // R3
    sr_load_chk: assert property (@(posedge clk) disable iff (rst)
        sr_go_o |-> status_o[5:2] == $past(sr_data_i[5:2]));

    // R4
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && status_o[0]) |=> (!status_o[0] && !status_o[1]));

    // R6
    all_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o[3:2] == 2'b11) |-> !byte_ok_o);

    // R11
    single_go_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({arr_go_o, sr_go_o}));
endmodule

bind nvw_guard nvw_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wp_level_i (wp_level_i),
    .done_i     (done_i),
    .sr_data_i  (sr_data_i),
    .status_o   (status_o),
    .byte_ok_o  (byte_ok_o),
    .arr_go_o   (arr_go_o),
    .sr_go_o    (sr_go_o)
);

// File: tb/tb_nvw_guard.sv
module tb_nvw_guard;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, por_i, wp_level_i, wren_i, wrdi_i;
    logic       sr_commit_i, arr_open_i, byte_vld_i, arr_commit_i, done_i;
    logic [7:0] sr_data_i;
    logic [8:0] byte_addr_i;
    logic [7:0] status_o;
    logic [1:0] wd_sel_o;
    logic       byte_ok_o, arr_go_o, sr_go_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvw_guard dut (
        .clk(clk), .rst(rst), .por_i(por_i), .wp_level_i(wp_level_i),
        .wren_i(wren_i), .wrdi_i(wrdi_i), .sr_commit_i(sr_commit_i),
        .sr_data_i(sr_data_i), .arr_open_i(arr_open_i), .byte_vld_i(byte_vld_i),
        .byte_addr_i(byte_addr_i), .arr_commit_i(arr_commit_i), .done_i(done_i),
        .status_o(status_o), .wd_sel_o(wd_sel_o), .byte_ok_o(byte_ok_o),
        .arr_go_o(arr_go_o), .sr_go_o(sr_go_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_wren;
        wren_i = 1'b1; tick; wren_i = 1'b0;
    endtask

    task automatic do_done;
        done_i = 1'b1; tick; done_i = 1'b0;
    endtask

    task automatic sr_write(logic [7:0] d);
        sr_data_i = d; sr_commit_i = 1'b1; tick; sr_commit_i = 1'b0;
    endtask

    task automatic put_byte(logic [8:0] a);
        byte_addr_i = a; byte_vld_i = 1'b1; tick; byte_vld_i = 1'b0;
    endtask

    task automatic open_page;
        arr_open_i = 1'b1; tick; arr_open_i = 1'b0;
    endtask

    task automatic commit_page;
        arr_commit_i = 1'b1; tick; arr_commit_i = 1'b0;
    endtask

    task automatic probe(logic [8:0] a, int exp, string tag);
        byte_addr_i = a; #1;
        check(tag, byte_ok_o, exp);
    endtask

    task automatic t_reset;
        check("R1 status after reset", status_o, 8'h30);
        check("R1 wd_sel after reset", wd_sel_o, 2'b11);
        check("R1 no go after reset", {arr_go_o, sr_go_o}, 0);
    endtask

    task automatic t_latch;
        do_wren;
        check("R2 wren sets flag", status_o, 8'h32);
        wrdi_i = 1'b1; tick; wrdi_i = 1'b0;
        check("R2 wrdi clears flag", status_o, 8'h30);
        do_wren;
        por_i = 1'b1; tick; por_i = 1'b0;
        check("R2 por clears flag", status_o, 8'h30);
    endtask

    task automatic t_no_wel;
        sr_write(8'h0C);
        check("R5 status write without flag no go", sr_go_o, 0);
        check("R5 status unchanged", status_o, 8'h30);
        open_page; put_byte(9'h010); commit_page;
        check("R5 array write without flag no go", arr_go_o, 0);
        check("R8 busy stays low", status_o[0], 0);
    endtask

    task automatic t_sr_write;
        do_wren;
        sr_write(8'hD6);
        check("R3 sr_go pulse", sr_go_o, 1);
        check("R3 status loaded bits 5:2 only", status_o, 8'h17);
        check("R3 wd_sel follows", wd_sel_o, 2'b01);
        tick;
        check("R3 single go pulse", sr_go_o, 0);
        do_done;
        check("R4 done clears busy and flag", status_o, 8'h14);
    endtask

    task automatic t_quarter_page;
        do_wren;
        probe(9'h17F, 1, "R6 quarter 17F writable");
        probe(9'h180, 0, "R6 quarter 180 guarded");
        open_page; put_byte(9'h170); put_byte(9'h180); commit_page;
        check("R7 page with guarded byte no go", arr_go_o, 0);
        check("R7 flag kept and not busy", status_o, 8'h16);
        open_page; put_byte(9'h100); put_byte(9'h17F); commit_page;
        check("R7 clean page starts", arr_go_o, 1);
        check("R8 busy with go", status_o, 8'h17);
        do_done;
        check("R4 page done clears", status_o, 8'h14);
    endtask

    task automatic t_other_codes;
        do_wren; sr_write(8'h38); do_done;
        do_wren;
        probe(9'h0FF, 1, "R6 half 0FF writable");
        probe(9'h100, 0, "R6 half 100 guarded");
        sr_write(8'h3C); do_done;
        do_wren;
        probe(9'h000, 0, "R6 all 000 guarded");
        sr_write(8'h30); do_done;
        do_wren;
        probe(9'h1FF, 1, "R6 none 1FF writable");
        check("R6 status code none", status_o, 8'h32);
    endtask

    task automatic t_busy;
        open_page; put_byte(9'h010); commit_page;
        check("R11 first commit starts", arr_go_o, 1);
        do_wren;
        commit_page;
        check("R11 commit while busy rejected", arr_go_o, 0);
        sr_write(8'h0C);
        check("R11 status write while busy rejected", sr_go_o, 0);
        check("R11 config unchanged", status_o, 8'h33);
        wp_level_i = 1'b0; tick;
        check("R10 pin low keeps busy", status_o, 8'h31);
        wp_level_i = 1'b1;
        do_done;
        check("R10 done ends cycle", status_o, 8'h30);
    endtask

    task automatic t_wp_abort;
        do_wren;
        open_page; put_byte(9'h020);
        wp_level_i = 1'b0; tick;
        check("R9 pin low clears flag", status_o, 8'h30);
        do_wren;
        check("R9 wren blocked by pin", status_o, 8'h30);
        probe(9'h020, 0, "R9 no permit with pin low");
        wp_level_i = 1'b1;
        commit_page;
        check("R9 loaded write cancelled", arr_go_o, 0);
        check("R9 status after cancel", status_o, 8'h30);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; por_i = 1'b0; wp_level_i = 1'b1; wren_i = 1'b0; wrdi_i = 1'b0;
        sr_commit_i = 1'b0; sr_data_i = 8'h00; arr_open_i = 1'b0; byte_vld_i = 1'b0;
        byte_addr_i = 9'h000; arr_commit_i = 1'b0; done_i = 1'b0;
        repeat (3) tick;
        rst = 1'b0;
        tick;
        t_reset;
        t_latch;
        t_no_wel;
        t_sr_write;
        t_quarter_page;
        t_other_codes;
        t_busy;
        t_wp_abort;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule